// File: doc/BRIEF.md
# Keyboard Data Latch with Strobe Clear

This block is a memory-mapped keyboard input port that sits on the 16-bit address bus of an 8-bit processor. It holds the most recent key code in a single byte. Bits 6:0 carry the code, and bit 7 is a "key ready" flag. A keyboard front end hands in keys through a one-cycle valid pulse with a 7-bit code. The processor polls one address to see the byte. It reads a second address to acknowledge the key, which drops the flag.

The block also reports whether the current address falls inside the 4 KiB I/O window, so that an outer memory system can send such accesses through the I/O decode path instead of plain RAM. Inside that window, only the data address and the strobe address return anything. Every other read returns zero. Writes never change the latch.

Top module: `kbd_input_port`

## Requirements
- R1: After synchronous reset the latched byte is 0x00, so a read of the data address (0xC000) returns 0x00.
- R2: A cycle with `key_valid` high stores `key_code` in bits 6:0 and sets bit 7. A read of 0xC000 shows the byte from the next cycle on.
- R3: A read of the data address 0xC000 returns the latched byte in the same cycle, combinationally, and leaves the latch unchanged.
- R4: A read of the strobe address 0xC010 returns the latched byte with bit 7 already 0 in the same cycle. On the following clock edge, bit 7 of the latch is cleared and bits 6:0 are kept.
- R5: A key that arrives while bit 7 is still set replaces bits 6:0, and bit 7 stays set.
- R6: If a key arrives in the same cycle as a strobe read, the key wins. After the edge the latch holds the new code with bit 7 set.
- R7: `in_io_window` is high exactly when `bus_addr` lies in 0xC000..0xCFFF inclusive. It does not depend on `bus_rd` or `bus_wr`.
- R8: Reads of any address other than 0xC000 and 0xC010 return 0x00. This covers addresses inside the window and addresses outside it. `rd_data` is also 0x00 in any cycle that is not a read.
- R9: A cycle with `bus_wr` high is a write, even if `bus_rd` is also high. A write to 0xC000 or 0xC010 leaves the latch unchanged and does not clear bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| key_valid | input | 1 | One-cycle pulse: a new key is on `key_code` |
| key_code | input | 7 | Code of the arriving key |
| bus_addr | input | 16 | Processor address |
| bus_rd | input | 1 | Read cycle |
| bus_wr | input | 1 | Write cycle (takes precedence over `bus_rd`) |
| rd_data | output | 8 | Read data, combinational |
| in_io_window | output | 1 | Address lies in the I/O window |

## Verification
The whole internal state is one byte. Any error in it shows on `rd_data` at the next read of 0xC000, and the bench performs that read often. A flag that fails to clear, or that clears on a write, shows up one cycle after the strobe access or the write. A wrong priority between a key and a strobe shows in the cycle right after the collision. The reference model is compared on every clock, so a bad read mux or a bad window decode appears in the same cycle as the offending address.

// File: rtl/kbd_port_pkg.sv
package kbd_port_pkg;
    localparam int KEY_W = 7;

    typedef struct packed {
        logic             ready;
        logic [KEY_W-1:0] code;
    } key_byte_t;
endpackage

// File: rtl/kbd_addr_decode.sv
module kbd_addr_decode #(
    parameter int              ADDR_W      = 16,
    parameter logic [ADDR_W-1:0] WIN_LO      = 16'hC000,
    parameter logic [ADDR_W-1:0] WIN_HI      = 16'hCFFF,
    parameter logic [ADDR_W-1:0] DATA_ADDR   = 16'hC000,
    parameter logic [ADDR_W-1:0] STROBE_ADDR = 16'hC010
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_window,
    output logic              hit_data,
    output logic              hit_strobe
);
    always_comb begin
        in_window  = (addr >= WIN_LO) && (addr <= WIN_HI);
        hit_data   = in_window && (addr == DATA_ADDR);
        hit_strobe = in_window && (addr == STROBE_ADDR);
    end
endmodule

// File: rtl/kbd_key_latch.sv
module kbd_key_latch
    import kbd_port_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             key_valid,
    input  logic [KEY_W-1:0] key_code,
    input  logic             clear_req,
    output key_byte_t        latch_q
);
    typedef struct packed {
        key_byte_t latch;
    } state_t;

    state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (key_valid) begin
            state_d.latch.ready = 1'b1;
            state_d.latch.code  = key_code;
        end else if (clear_req) begin
            state_d.latch.ready = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign latch_q = state_q.latch;

    assert_key_sets_flag_R2: assert property (@(posedge clk) disable iff (rst)
        key_valid |=> latch_q.ready && (latch_q.code == $past(key_code)));

    // R6: key has priority over the clear
    assert_key_beats_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (key_valid && clear_req) |=> latch_q.ready);

    assert_clear_keeps_code_R4: assert property (@(posedge clk) disable iff (rst)
        (clear_req && !key_valid) |=> !latch_q.ready && $stable(latch_q.code));

    assert_idle_holds_R3: assert property (@(posedge clk) disable iff (rst)
        (!clear_req && !key_valid) |=> $stable(latch_q));
endmodule

// File: rtl/kbd_read_mux.sv
module kbd_read_mux
    import kbd_port_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              rd_en,
    input  logic              hit_data,
    input  logic              hit_strobe,
    input  key_byte_t         latch_q,
    output logic [DATA_W-1:0] rd_data
);
    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            if (hit_data)        rd_data = latch_q;
            else if (hit_strobe) rd_data = {1'b0, latch_q.code};
        end
    end
endmodule

// File: rtl/kbd_input_port.sv
module kbd_input_port
    import kbd_port_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              key_valid,
    input  logic [KEY_W-1:0]  key_code,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    output logic [DATA_W-1:0] rd_data,
    output logic              in_io_window
);
    localparam logic [ADDR_W-1:0] DATA_ADDR   = ADDR_W'(16'hC000);
    localparam logic [ADDR_W-1:0] STROBE_ADDR = ADDR_W'(16'hC010);

    logic      hit_data, hit_strobe, rd_en;
    key_byte_t latch_q;

    assign rd_en = bus_rd && !bus_wr;

    kbd_addr_decode #(
        .ADDR_W(ADDR_W), .WIN_LO(ADDR_W'(16'hC000)), .WIN_HI(ADDR_W'(16'hCFFF)),
        .DATA_ADDR(DATA_ADDR), .STROBE_ADDR(STROBE_ADDR)
    ) i_dec (
        .addr(bus_addr), .in_window(in_io_window),
        .hit_data(hit_data), .hit_strobe(hit_strobe)
    );

    kbd_key_latch i_latch (
        .clk(clk), .rst(rst), .key_valid(key_valid), .key_code(key_code),
        .clear_req(rd_en && hit_strobe), .latch_q(latch_q)
    );

    kbd_read_mux #(.DATA_W(DATA_W)) i_mux (
        .rd_en(rd_en), .hit_data(hit_data), .hit_strobe(hit_strobe),
        .latch_q(latch_q), .rd_data(rd_data)
    );

    assert_strobe_read_flag_low_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_wr && bus_addr == STROBE_ADDR) |-> !rd_data[DATA_W-1]);

    assert_write_keeps_latch_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !key_valid) |=> $stable(latch_q));

    assert_out_window_zero_R8: assert property (@(posedge clk) disable iff (rst)
        !in_io_window |-> (rd_data == '0));
endmodule

// File: tb/test_kbd_input_port.sv
module test_kbd_input_port;
    logic        clk = 1'b0;
    logic        rst;
    logic        key_valid;
    logic [6:0]  key_code;
    logic [15:0] bus_addr;
    logic        bus_rd, bus_wr;
    logic [7:0]  rd_data;
    logic        in_io_window;

    int n_checks = 0;
    int n_fail   = 0;
    int model    = 0;
    bit done     = 0;

    always #10 clk = ~clk;

    kbd_input_port i_kbd_input_port (
        .clk(clk), .rst(rst), .key_valid(key_valid), .key_code(key_code),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .rd_data(rd_data), .in_io_window(in_io_window)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // One bus cycle: drive at negedge, compare comb outputs, update model at posedge
    task automatic cyc(input string req, input logic [15:0] a, input bit rd, input bit wr,
                       input bit kv, input logic [6:0] kc);
        int exp_rd;
        bit is_rd, win;
        @(negedge clk);
        bus_addr = a; bus_rd = rd; bus_wr = wr; key_valid = kv; key_code = kc;
        #2;
        is_rd  = rd && !wr;
        win    = (a >= 16'hC000) && (a <= 16'hCFFF);
        exp_rd = 0;
        if (is_rd && a == 16'hC000) exp_rd = model;
        if (is_rd && a == 16'hC010) exp_rd = model & 8'h7F;
        check({req, " rd_data"}, int'(rd_data), exp_rd);
        check("R7 window", int'(in_io_window), int'(win));
        @(posedge clk);
        if (kv) model = 8'h80 | int'(kc);
        else if (is_rd && a == 16'hC010) model = model & 8'h7F;
    endtask

    task automatic rd_data_addr(input string req);
        cyc(req, 16'hC000, 1, 0, 0, 7'h0);
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        rst = 1; key_valid = 0; key_code = 0; bus_addr = 0; bus_rd = 0; bus_wr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        model = 0;
        rd_data_addr("R1 reset");
        cyc("R2 key in", 16'h0000, 0, 0, 1, 7'h41);
        rd_data_addr("R2 key visible");
        rd_data_addr("R3 read no side effect");
        cyc("R4 strobe read", 16'hC010, 1, 0, 0, 7'h0);
        rd_data_addr("R4 flag cleared");
        cyc("R5 key 1", 16'h1234, 0, 0, 1, 7'h11);
        cyc("R5 overwrite", 16'h1234, 0, 0, 1, 7'h7F);
        rd_data_addr("R5 new code");
        cyc("R6 collide", 16'hC010, 1, 0, 1, 7'h22);
        rd_data_addr("R6 key wins");
        cyc("R9 write data", 16'hC000, 0, 1, 0, 7'h0);
        cyc("R9 write strobe", 16'hC010, 0, 1, 0, 7'h0);
        cyc("R9 rd+wr strobe", 16'hC010, 1, 1, 0, 7'h0);
        rd_data_addr("R9 flag kept");
        cyc("R8 in window", 16'hC001, 1, 0, 0, 7'h0);
        cyc("R8 window top", 16'hCFFF, 1, 0, 0, 7'h0);
        cyc("R8 below", 16'hBFFF, 1, 0, 0, 7'h0);
        cyc("R8 above", 16'hD000, 1, 0, 0, 7'h0);
        cyc("R8 no read", 16'hC000, 0, 0, 0, 7'h0);
        for (int i = 0; i < 400; i++) begin
            logic [15:0] a;
            case ($urandom_range(0, 5))
                0: a = 16'hC000;
                1: a = 16'hC010;
                2: a = 16'hC000 | 16'($urandom_range(0, 16'h0FFF));
                3: a = 16'($urandom);
                4: a = 16'hBFFF;
                default: a = 16'hD000;
            endcase
            cyc("R3 random mix", a, 1'($urandom), 1'($urandom_range(0, 3) == 0),
                1'($urandom_range(0, 3) == 0), 7'($urandom));
        end
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0; model = 0;
        rd_data_addr("R1 second reset");
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule